// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a set of free-running clock sources and the output pins. It parks those clocks and restarts them without ever emitting a runt pulse. Two things can stop a clock. The first is an asynchronous power-down request, which is qualified against a reference clock (the complement leg of the CPU clock). The second is a software run bit, which is active low. Each output carries three configuration bits. An enable bit overrides everything else. A stoppable bit decides whether the software run bit affects that output. Each differential pair also has a park-mode bit that selects how the pair is held while stopped.

Single-ended outputs stop and restart only while their raw clock is low. Each one therefore parks low and always restarts with a full high phase. Differential pairs change state at the rising edge of the true leg, which is the falling edge of the complement leg. They park with the true leg high and the complement leg released, or with both legs released. Each output's gate request passes through a synchroniser of its own, clocked in that output's domain.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low, every `se_out` bit is 0 and every `diff_oe_t` and `diff_oe_c` bit is 0.
- R2: Power-down becomes active only after `pd_req` has been sampled high on two consecutive rising edges of `ref_clk`. A high pulse that is seen by one edge only stops nothing.
- R3: Under power-down, each single-ended output is held low. The gate request is sampled on falling edges of the output's own raw clock through a two-stage synchroniser, so the output stops at the second such falling edge after the request is stable. The output can only fall together with its raw clock.
- R4: Each differential pair takes a new gate state only at a rising edge of its true leg (a falling edge of its complement leg), using the same two-edge synchroniser. A stopped pair holds `diff_out_t` at 1 for as long as the true leg is driven.
- R5: Park mode is selected by `diff_park_z`. A value of 0 parks a stopped pair with `diff_oe_t`=1 and `diff_oe_c`=0. A value of 1 parks it with both enables at 0.
- R6: When `sw_go` is 0, every output whose stoppable bit is 1 stops. Outputs whose stoppable bit is 0 keep running.
- R7: When `sw_go` returns to 1, or power-down ends, stopped outputs restart at their next qualifying edge. A single-ended output restarts at a falling edge, so its first high phase is full width. Every output restarts within two of its own clock periods.
- R8: An enable bit of 0 forces a single-ended output low, and forces both enables of a differential pair to 0, whatever the state of power-down, the run bit or the park mode.
- R9: A running pair drives `diff_out_c` as the inverse of `diff_out_t`, with both enables at 1. `diff_oe_c` is never 1 while `diff_oe_t` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that qualifies power-down (CPU complement leg) |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| pd_req | input | 1 | Asynchronous power-down request, active high |
| sw_go | input | 1 | Software run bit: 0 stops stoppable outputs, 1 runs them |
| se_clk | input | NUM_SE | Raw single-ended clocks |
| se_en | input | NUM_SE | Per-output enable for single-ended clocks |
| se_stoppable | input | NUM_SE | 1: single-ended output follows `sw_go` |
| diff_clk | input | NUM_DIFF | Raw true leg of each differential clock |
| diff_en | input | NUM_DIFF | Per-pair enable |
| diff_stoppable | input | NUM_DIFF | 1: pair follows `sw_go` |
| diff_park_z | input | NUM_DIFF | Park mode: 0 true high and complement released, 1 both released |
| se_out | output | NUM_SE | Gated single-ended clocks |
| diff_out_t | output | NUM_DIFF | Gated true legs |
| diff_out_c | output | NUM_DIFF | Gated complement legs |
| diff_oe_t | output | NUM_DIFF | Drive enable of true legs |
| diff_oe_c | output | NUM_DIFF | Drive enable of complement legs |

## Verification
A stale or corrupted synchroniser stage shows at the ports as an output that stops or restarts one of its own clock edges early or late. It also shows as a high phase cut short where the gate moved while the clock was high. Either is visible within one period of the affected clock. A wrong power-down qualifier lets a single-edge pulse park every output, which is visible within three reference edges. The bench keeps its own edge-by-edge model of every output domain and compares all legs and enables on every reference clock. The checker also watches that a single-ended output only rises and falls together with its raw clock, and that a driven parked true leg stays high. The checker assumes that `ref_clk` is faster than every gated clock.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

   typedef enum logic {
      PARK_TRUE_HIGH = 1'b0,
      PARK_ALL_Z     = 1'b1
   } park_mode_e;

   // Gate request seen by one output: run unless disabled, powered down,
   // or software-stopped while marked stoppable.
   function automatic logic gate_want(input logic en, input logic stoppable,
                                      input logic go, input logic pd);
      return en & ~(pd | (stoppable & ~go));
   endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
   parameter int WIDTH   = 1,
   parameter int STAGES  = 2,
   parameter bit ON_FALL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("clkstop_sync: STAGES must be at least 2");
   end

   if (ON_FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d};
      end
   end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/clkstop_pd_qual.sv
`timescale 1ns/1ps
module clkstop_pd_qual #(
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic pd_req,
   output logic pd_active
);

   logic pd_sync;
   logic pd_prev;

   clkstop_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .ON_FALL(1'b0)) u_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (pd_req),
      .q     (pd_sync)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) pd_prev <= 1'b0;
      else        pd_prev <= pd_sync;
   end

   // two consecutive high samples qualify the request
   assign pd_active = pd_sync & pd_prev;

endmodule

// File: rtl/clkstop_se_gate.sv
`timescale 1ns/1ps
module clkstop_se_gate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic want,
   output logic clk_out
);

   logic run;

   // sampled on falling edges: the gate only moves while the clock is low
   clkstop_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .ON_FALL(1'b1)) u_sync (
      .clk   (clk_in),
      .rst_n (rst_n),
      .d     (want),
      .q     (run)
   );

   assign clk_out = clk_in & run;

endmodule

// File: rtl/clkstop_diff_gate.sv
`timescale 1ns/1ps
module clkstop_diff_gate
   import clkstop_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_in,
   input  logic       rst_n,
   input  logic       en,
   input  logic       want,
   input  park_mode_e park,
   output logic       out_t,
   output logic       out_c,
   output logic       oe_t,
   output logic       oe_c
);

   logic [1:0] state;
   logic       en_q;
   logic       run_q;

   // rising edge of the true leg is the falling edge of the complement leg
   clkstop_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .ON_FALL(1'b0)) u_sync (
      .clk   (clk_in),
      .rst_n (rst_n),
      .d     ({en, want}),
      .q     (state)
   );

   assign en_q  = state[1];
   assign run_q = state[0];

   assign out_t = run_q ? clk_in  : en_q;
   assign out_c = run_q ? ~clk_in : 1'b0;
   assign oe_t  = run_q | (en_q & (park == PARK_TRUE_HIGH));
   assign oe_c  = run_q;

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
   import clkstop_pkg::*;
#(
   parameter int NUM_SE      = 2,
   parameter int NUM_DIFF    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                ref_clk,
   input  logic                rst_n,
   input  logic                pd_req,
   input  logic                sw_go,
   input  logic [NUM_SE-1:0]   se_clk,
   input  logic [NUM_SE-1:0]   se_en,
   input  logic [NUM_SE-1:0]   se_stoppable,
   input  logic [NUM_DIFF-1:0] diff_clk,
   input  logic [NUM_DIFF-1:0] diff_en,
   input  logic [NUM_DIFF-1:0] diff_stoppable,
   input  logic [NUM_DIFF-1:0] diff_park_z,
   output logic [NUM_SE-1:0]   se_out,
   output logic [NUM_DIFF-1:0] diff_out_t,
   output logic [NUM_DIFF-1:0] diff_out_c,
   output logic [NUM_DIFF-1:0] diff_oe_t,
   output logic [NUM_DIFF-1:0] diff_oe_c
);

   if (NUM_SE < 1) begin : g_bad_se
      $error("clkstop_ctrl: NUM_SE must be at least 1");
   end
   if (NUM_DIFF < 1) begin : g_bad_diff
      $error("clkstop_ctrl: NUM_DIFF must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkstop_ctrl: SYNC_STAGES must be at least 2");
   end

   logic pd_active;

   clkstop_pd_qual #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
      .ref_clk   (ref_clk),
      .rst_n     (rst_n),
      .pd_req    (pd_req),
      .pd_active (pd_active)
   );

   for (genvar i = 0; i < NUM_SE; i++) begin : g_se
      logic want;
      assign want = gate_want(se_en[i], se_stoppable[i], sw_go, pd_active);
      clkstop_se_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
         .clk_in  (se_clk[i]),
         .rst_n   (rst_n),
         .want    (want),
         .clk_out (se_out[i])
      );
   end

   for (genvar j = 0; j < NUM_DIFF; j++) begin : g_diff
      logic want;
      assign want = gate_want(diff_en[j], diff_stoppable[j], sw_go, pd_active);
      clkstop_diff_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
         .clk_in (diff_clk[j]),
         .rst_n  (rst_n),
         .en     (diff_en[j]),
         .want   (want),
         .park   (park_mode_e'(diff_park_z[j])),
         .out_t  (diff_out_t[j]),
         .out_c  (diff_out_c[j]),
         .oe_t   (diff_oe_t[j]),
         .oe_c   (diff_oe_c[j])
      );
   end

endmodule

// File: rtl/clkstop_checker.sv
`timescale 1ns/1ps
module clkstop_checker #(
   parameter int NUM_SE      = 2,
   parameter int NUM_DIFF    = 2,
   parameter int SYNC_STAGES = 2
) (
   input logic                ref_clk,
   input logic                rst_n,
   input logic                pd_req,
   input logic                pd_active,
   input logic [NUM_SE-1:0]   se_clk,
   input logic [NUM_SE-1:0]   se_out,
   input logic [NUM_DIFF-1:0] diff_out_t,
   input logic [NUM_DIFF-1:0] diff_oe_t,
   input logic [NUM_DIFF-1:0] diff_oe_c
);

   logic [1:0] edges_seen;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)                 edges_seen <= 2'd0;
      else if (edges_seen != 2'd3) edges_seen <= edges_seen + 2'd1;
   end

   if (SYNC_STAGES == 2) begin : g_pd_chk
      assert_pd_qualify_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
         (edges_seen == 2'd3) |-> (pd_active == ($past(pd_req, 2) && $past(pd_req, 3))));
   end

   for (genvar i = 0; i < NUM_SE; i++) begin : g_se_chk
      assert_se_rise_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
         $rose(se_out[i]) |-> se_clk[i]);
      assert_se_fall_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
         $fell(se_out[i]) |-> !se_clk[i]);
   end

   for (genvar j = 0; j < NUM_DIFF; j++) begin : g_diff_chk
      assert_park_true_high_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
         (diff_oe_t[j] && !diff_oe_c[j]) |-> diff_out_t[j]);
      assert_comp_needs_true_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
         diff_oe_c[j] |-> diff_oe_t[j]);
   end

endmodule

bind clkstop_ctrl clkstop_checker #(
   .NUM_SE      (NUM_SE),
   .NUM_DIFF    (NUM_DIFF),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .ref_clk    (ref_clk),
   .rst_n      (rst_n),
   .pd_req     (pd_req),
   .pd_active  (pd_active),
   .se_clk     (se_clk),
   .se_out     (se_out),
   .diff_out_t (diff_out_t),
   .diff_oe_t  (diff_oe_t),
   .diff_oe_c  (diff_oe_c)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;

   localparam int NSE = 2;
   localparam int NDF = 2;
   localparam int STG = 2;

   logic           ref_clk = 1'b0;
   logic           rst_n   = 1'b0;
   logic           pd_req  = 1'b0;
   logic           sw_go   = 1'b1;
   logic [NSE-1:0] se_clk  = '0;
   logic [NSE-1:0] se_en   = '1;
   logic [NSE-1:0] se_stop_ok = 2'b10;
   logic [NDF-1:0] df_clk  = '0;
   logic [NDF-1:0] df_en   = '1;
   logic [NDF-1:0] df_stop_ok = 2'b10;
   logic [NDF-1:0] df_park = 2'b00;

   logic [NSE-1:0] se_out;
   logic [NDF-1:0] df_t, df_c, df_oet, df_oec;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   clkstop_ctrl #(.NUM_SE(NSE), .NUM_DIFF(NDF), .SYNC_STAGES(STG)) i_clkstop_ctrl (
      .ref_clk        (ref_clk),
      .rst_n          (rst_n),
      .pd_req         (pd_req),
      .sw_go          (sw_go),
      .se_clk         (se_clk),
      .se_en          (se_en),
      .se_stoppable   (se_stop_ok),
      .diff_clk       (df_clk),
      .diff_en        (df_en),
      .diff_stoppable (df_stop_ok),
      .diff_park_z    (df_park),
      .se_out         (se_out),
      .diff_out_t     (df_t),
      .diff_out_c     (df_c),
      .diff_oe_t      (df_oet),
      .diff_oe_c      (df_oec)
   );

   // 200 MHz reference; gated clocks have edges offset by 1 ns from the grid
   always #2.5 ref_clk = ~ref_clk;
   initial begin #1; forever #15 se_clk[0] = ~se_clk[0]; end
   initial begin #1; forever #10 se_clk[1] = ~se_clk[1]; end
   initial begin #1; forever #5  df_clk[0] = ~df_clk[0]; end
   initial begin #1; forever #10 df_clk[1] = ~df_clk[1]; end

   // ---------------- reference model ----------------
   logic [2:0] pd_hist = '0;
   logic       m_pd    = 1'b0;

   always @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_hist = '0;
      end else begin
         pd_hist = {pd_hist[1:0], pd_req};
      end
      m_pd = pd_hist[1] & pd_hist[2];
   end

   logic [NSE-1:0] m_se_run;
   logic [NDF-1:0] m_df_run, m_df_en;

   for (genvar i = 0; i < NSE; i++) begin : g_mse
      logic hist[$];
      logic eff = 1'b0;
      always @(negedge se_clk[i] or negedge rst_n) begin
         if (!rst_n) begin
            hist = {};
            repeat (STG - 1) hist.push_back(1'b0);
            eff = 1'b0;
         end else begin
            hist.push_back(se_en[i] & ~(m_pd | (se_stop_ok[i] & ~sw_go)));
            eff = hist.pop_front();
         end
      end
      assign m_se_run[i] = eff;
   end

   for (genvar j = 0; j < NDF; j++) begin : g_mdf
      logic [1:0] hist[$];
      logic [1:0] eff = 2'b00;
      always @(posedge df_clk[j] or negedge rst_n) begin
         if (!rst_n) begin
            hist = {};
            repeat (STG - 1) hist.push_back(2'b00);
            eff = 2'b00;
         end else begin
            hist.push_back({df_en[j], df_en[j] & ~(m_pd | (df_stop_ok[j] & ~sw_go))});
            eff = hist.pop_front();
         end
      end
      assign m_df_en[j]  = eff[1];
      assign m_df_run[j] = eff[0];
   end

   // ---------------- checking ----------------
   task automatic chk(input string req, input string what, input logic [3:0] act,
                      input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      for (int i = 0; i < NSE; i++) begin
         string r;
         if (!se_en[i])                        r = "R8";
         else if (m_pd)                        r = "R3";
         else if (se_stop_ok[i] && !sw_go)     r = "R6";
         else                                  r = "R7";
         chk(r, $sformatf("se_out[%0d]", i), {3'b0, se_out[i]},
             {3'b0, m_se_run[i] & se_clk[i]});
      end
      for (int j = 0; j < NDF; j++) begin
         string r;
         logic [3:0] exp;
         if (!m_df_en[j])      r = "R8";
         else if (m_df_run[j]) r = "R9";
         else if (df_park[j])  r = "R5";
         else                  r = "R4";
         exp = {m_df_run[j] ? df_clk[j] : m_df_en[j],
                m_df_run[j] ? ~df_clk[j] : 1'b0,
                m_df_run[j] | (m_df_en[j] & ~df_park[j]),
                m_df_run[j]};
         chk(r, $sformatf("diff[%0d] {t,c,oet,oec}", j),
             {df_t[j], df_c[j], df_oet[j], df_oec[j]}, exp);
      end
   endtask

   initial begin
      forever begin
         @(posedge ref_clk);
         #3;
         if (rst_n && !done) compare_all();
      end
   end

   int se0_rises = 0;
   int se1_rises = 0;
   always @(posedge se_out[0]) se0_rises++;
   always @(posedge se_out[1]) se1_rises++;

   task automatic step(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #50000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      step(4);
      // R1: reset state
      chk("R1", "se_out in reset", {2'b0, se_out}, 4'b0);
      chk("R1", "diff enables in reset", {df_oet, df_oec}, 4'b0);
      step(6);
      rst_n = 1'b1;
      step(40);

      // R2: a pulse seen by one reference edge only stops nothing
      se0_rises = 0;
      pd_req = 1'b1;
      step(1);
      pd_req = 1'b0;
      step(40);
      chk("R2", "diff_oe_c after single-edge pulse", {2'b0, df_oec}, 4'b0011);
      chk("R2", "se_out[0] kept toggling", {3'b0, se0_rises > 0}, 4'b0001);

      // R6: software stop parks only stoppable outputs
      sw_go = 1'b0;
      step(20);
      se0_rises = 0;
      se1_rises = 0;
      step(30);
      chk("R6", "stoppable se_out[1] rises", {3'b0, se1_rises > 0}, 4'b0000);
      chk("R6", "free-running se_out[0] rises", {3'b0, se0_rises > 0}, 4'b0001);
      chk("R6", "free pair 0 running, pair 1 parked", {df_oet, df_oec}, 4'b1101);
      // R7: resume
      sw_go = 1'b1;
      step(40);
      chk("R7", "all pairs running again", {2'b0, df_oec}, 4'b0011);

      // R3, R4, R5: power-down with mixed park modes
      df_park = 2'b10;
      pd_req = 1'b1;
      step(40);
      chk("R3", "se_out held low", {2'b0, se_out}, 4'b0);
      chk("R5", "pair0 true driven, pair1 released", {df_oet, df_oec}, 4'b0100);
      chk("R4", "pair0 true leg high", {3'b0, df_t[0]}, 4'b0001);
      pd_req = 1'b0;
      step(40);
      df_park = 2'b01;
      pd_req = 1'b1;
      step(40);
      chk("R5", "swapped park modes", {df_oet, df_oec}, 4'b1000);
      pd_req = 1'b0;
      step(40);
      chk("R7", "restart after power-down", {2'b0, df_oec}, 4'b0011);

      // R8: disable overrides power-down, stop and park mode
      se_en = 2'b01;
      df_en = 2'b01;
      df_park = 2'b00;
      step(40);
      chk("R8", "disabled pair1 released", {df_oet[1], df_oec[1], 2'b0}, 4'b0);
      pd_req = 1'b1;
      sw_go  = 1'b0;
      step(40);
      chk("R8", "disabled outputs under power-down",
          {se_out[1], df_oet[1], df_oec[1], 1'b0}, 4'b0);
      pd_req = 1'b0;
      sw_go  = 1'b1;
      se_en  = 2'b11;
      df_en  = 2'b11;
      step(40);
      chk("R9", "all pairs running at end", {df_oet, df_oec}, 4'b1111);

      finish_run();
   end

endmodule